// File: doc/BRIEF.md
# Pipelined ADC Digital Correction

This block is the digital back end of a ten-stage pipelined analog-to-digital converter. Each pipeline stage makes a coarse three-level decision about the sample it holds. It makes that decision half a clock period after the stage before it. The block captures every stage's decision on the clock edge at which that stage resolves. It then passes the decision down a short chain of registers that alternate between rising and falling edges, so that all ten decisions for one sample reach the combining adder in the same half-cycle.

The adder weights each signed digit by a power of two, adds a mid-scale offset and clamps the sum into a 10-bit straight offset binary word. The word is registered on a rising edge. Because adjacent stages overlap by one digit, a wrong decision made by a comparator with an offset in one stage is made up by the stages after it, and no output code goes missing. A valid flag tells the consumer when the pipeline holds only samples taken after reset.

Top module: `adcc_top`

## Requirements
- R1: A sample is taken on a falling clock edge, and its word appears on `dataOut` 5.5 clock periods later, on the 11th clock edge counted from the sampling edge, which is a rising edge. Stage k (0 to 9) must present its digit for that sample during the half-period that ends on the (k+1)-th edge after the sampling edge. Even-numbered stages are therefore captured on rising edges and odd-numbered stages on falling edges.
- R2: A stage digit is encoded as 2'b00 = -1, 2'b01 = 0 and 2'b10 = +1. The illegal code 2'b11 gives exactly the same result as 2'b01.
- R3: The word equals 512 plus the sum of d_k * 2^(9-k). Stage 0 is the first stage and carries weight 512, and stage 9 carries weight 1. Stage k's digit sits on `stageDec[2k+1:2k]`.
- R4: The coding is straight offset binary. All-zero digits give 10 0000 0000 (512). A sum at or below negative full scale gives 00 0000 0000. A single -1 in the last stage gives 01 1111 1111 (511).
- R5: Two digit sets with the same weighted sum give the same word. For example, +1 in stage 0 with -1 in stage 1 equals +1 in stage 1 alone. This lets later stages absorb an error in an earlier stage.
- R6: A sum above 1023 is clamped to 11 1111 1111, and a sum below 0 is clamped to 0.
- R7: A synchronous active-high `rst` clears every delay register and `dataOut` to 0, and drives `validOut` low on the next rising edge.
- R8: After `rst` is released between a falling edge and a rising edge, `validOut` stays low for the first 5 rising edges and goes high on the 6th. It then stays high until the next reset.
- R9: A new sample is accepted on every falling edge. Back-to-back samples with different digits each produce their own word, with no mixing between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| stageDec | input | 20 | Ten 2-bit stage decisions, stage k on bits [2k+1:2k] |
| dataOut | output | 10 | Corrected straight offset binary word |
| validOut | output | 1 | High once the pipeline has filled after reset |

## Verification
The hardest situation to reach is the one where ten different samples are in flight at once. In that state each stage input carries a digit that belongs to a different sample, and the inputs change every half-cycle on alternating edges. The stimulus reaches it by streaming a table of samples back to back. A half-cycle counter decides, after every edge, which sample each stage input must now carry. Any misaligned tap or wrong edge then combines digits from neighbouring samples and produces a mismatching word. Redundant digit pairs and illegal codes are placed next to entries with very different sums, so that a misalignment also changes the result.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

  typedef struct packed {
    logic clr;
    logic outValid;
  } strobe_t;

  // 2-bit stage code to signed digit; the unused code counts as zero
  function automatic logic signed [1:0] digitOf(input logic [1:0] code);
    case (code)
      2'b00:   digitOf = -2'sd1;
      2'b10:   digitOf = 2'sd1;
      default: digitOf = 2'sd0;
    endcase
  endfunction

endpackage

// File: rtl/adcc_align.sv
module adcc_align #(
  parameter int STAGES = 10
) (
  input  logic       clk,
  input  logic       clr,
  input  logic [1:0] stageIn [STAGES],
  output logic [1:0] aligned [STAGES]
);

  // Stage k is captured on half-cycle k+1 after sampling and must reach
  // half-cycle STAGES; tap j lives on half-cycle k+1+j (odd = rising edge).
  for (genvar k = 0; k < STAGES; k++) begin : gStage
    localparam int DEPTH = STAGES - k;
    for (genvar j = 0; j < DEPTH; j++) begin : gTap
      logic [1:0] q;
      logic [1:0] d;
      if (j == 0) begin : gHead
        assign d = stageIn[k];
      end else begin : gLink
        assign d = gTap[j-1].q;
      end
      if (((k + j) % 2) == 0) begin : gRise
        always_ff @(posedge clk) begin
          if (clr) q <= '0;
          else     q <= d;
        end
      end else begin : gFall
        always_ff @(negedge clk) begin
          if (clr) q <= '0;
          else     q <= d;
        end
      end
    end
    assign aligned[k] = gTap[DEPTH-1].q;
  end

endmodule

// File: rtl/adcc_merge.sv
module adcc_merge #(
  parameter int STAGES = 10
) (
  input  logic                   clk,
  input  adcc_pkg::strobe_t      strobes,
  input  logic [1:0]             aligned [STAGES],
  output logic [STAGES-1:0]      dataOut
);
  import adcc_pkg::*;

  localparam int OUT_W = STAGES;
  localparam int SUM_W = OUT_W + 2;
  localparam logic signed [SUM_W-1:0] MID  = SUM_W'(1 << (OUT_W - 1));
  localparam logic signed [SUM_W-1:0] TOPV = SUM_W'((1 << OUT_W) - 1);

  logic signed [SUM_W-1:0] acc;
  logic [OUT_W-1:0]        clamped;

  always_comb begin
    acc = MID;
    for (int k = 0; k < STAGES; k++) begin
      acc = acc + (SUM_W'(digitOf(aligned[k])) <<< (STAGES - 1 - k));
    end
  end

  always_comb begin
    if (acc < 0)         clamped = '0;
    else if (acc > TOPV) clamped = '1;
    else                 clamped = acc[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobes.clr) dataOut <= '0;
    else             dataOut <= clamped;
  end

endmodule

// File: rtl/adcc_ctrl.sv
module adcc_ctrl #(
  parameter int STAGES = 10
) (
  input  logic              clk,
  input  logic              rst,
  output adcc_pkg::strobe_t strobes
);

  localparam int FILL = (STAGES + 2) / 2;
  localparam int CW   = $clog2(FILL + 1);

  logic [CW-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst)                        fillCnt <= '0;
    else if (fillCnt != CW'(FILL))  fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    strobes.clr      = rst;
    strobes.outValid = (fillCnt == CW'(FILL));
  end

endmodule

// File: rtl/adcc_top.sv
module adcc_top #(
  parameter int STAGES = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*STAGES-1:0]   stageDec,
  output logic [STAGES-1:0]     dataOut,
  output logic                  validOut
);
  import adcc_pkg::*;

  strobe_t    strobes;
  logic [1:0] stageArr [STAGES];
  logic [1:0] aligned  [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : gUnpack
    assign stageArr[k] = stageDec[2*k +: 2];
  end

  adcc_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  adcc_align #(.STAGES(STAGES)) u_align (
    .clk     (clk),
    .clr     (strobes.clr),
    .stageIn (stageArr),
    .aligned (aligned)
  );

  adcc_merge #(.STAGES(STAGES)) u_merge (
    .clk     (clk),
    .strobes (strobes),
    .aligned (aligned),
    .dataOut (dataOut)
  );

  assign validOut = strobes.outValid;

endmodule

// File: rtl/adcc_check.sv
module adcc_check #(
  parameter int STAGES = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [STAGES-1:0] dataOut,
  input logic              validOut
);

  localparam int FILL = (STAGES + 2) / 2;

  logic [7:0] risesSinceRst;

  always_ff @(posedge clk) begin
    if (rst)                    risesSinceRst <= '0;
    else if (risesSinceRst != 8'hFF) risesSinceRst <= risesSinceRst + 1'b1;
  end

  assert_reset_clears_data_R7: assert property (@(posedge clk)
    rst |=> (dataOut == '0));

  assert_reset_drops_valid_R7: assert property (@(posedge clk)
    rst |=> !validOut);

  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    validOut |=> validOut);

  assert_valid_not_early_R8: assert property (@(posedge clk) disable iff (rst)
    (risesSinceRst < 8'(FILL)) |-> !validOut);

  assert_valid_not_late_R8: assert property (@(posedge clk) disable iff (rst)
    (risesSinceRst >= 8'(FILL)) |-> validOut);

endmodule

bind adcc_top adcc_check #(.STAGES(STAGES)) u_check (
  .clk      (clk),
  .rst      (rst),
  .dataOut  (dataOut),
  .validOut (validOut)
);

// File: tb/adcc_top_tb.sv
`timescale 1ns/1ps
module adcc_top_tb;

  localparam int STAGES = 10;
  localparam int NV     = 12;
  localparam logic [1:0] M = 2'b00;
  localparam logic [1:0] Z = 2'b01;
  localparam logic [1:0] P = 2'b10;
  localparam logic [1:0] X = 2'b11;

  // {stage9 ... stage0}
  localparam logic [2*STAGES-1:0] STIM [NV] = '{
    {10{Z}},
    {10{P}},
    {10{M}},
    {{8{Z}}, M, P},
    {{8{Z}}, P, Z},
    {P, {9{Z}}},
    {M, {9{Z}}},
    {10{X}},
    {{7{Z}}, P, P, M},
    {{8{Z}}, P, X},
    {5{M, P}},
    {{9{P}}, M}
  };
  localparam int EXPV [NV] = '{512, 1023, 0, 768, 768, 513, 511, 512, 384, 768, 853, 511};

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [2*STAGES-1:0]   stageDec = {STAGES{Z}};
  logic [STAGES-1:0]     dataOut;
  logic                  validOut;

  int checks = 0;
  int fails  = 0;

  adcc_top #(.STAGES(STAGES)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .stageDec (stageDec),
    .dataOut  (dataOut),
    .validOut (validOut)
  );

  always #2.5 clk = ~clk;

  function automatic string tagOf(input int n);
    case (n)
      0, 2, 6: tagOf = "R4";
      1:       tagOf = "R6";
      3, 4, 11: tagOf = "R5";
      5, 8:    tagOf = "R3";
      7, 9:    tagOf = "R2";
      default: tagOf = "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R9: samples back to back, one per falling edge; h counts edges from sample 0
  task automatic runStream();
    int h;
    int last;
    last = 2 * (NV - 1) + 11;
    @(negedge clk);
    h = 0;
    while (h <= last) begin
      #1;
      for (int k = 0; k < STAGES; k++) begin
        if (h >= k && ((h - k) % 2) == 0) begin
          int n;
          n = (h - k) / 2;
          stageDec[2*k +: 2] = (n < NV) ? STIM[n][2*k +: 2] : Z;
        end
      end
      if (h >= 11 && ((h - 11) % 2) == 0) begin
        int n;
        n = (h - 11) / 2;
        chk(validOut && (int'(dataOut) == EXPV[n]), {tagOf(n), " R9 stream"},
            int'(dataOut), EXPV[n]);
      end
      @(clk);
      h++;
    end
  endtask

  initial begin
    #500000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(dataOut == '0, "R7 reset data", int'(dataOut), 0);
    chk(!validOut, "R7 reset valid", int'(validOut), 0);

    @(negedge clk);
    #1 rst = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(posedge clk);
      #1;
      chk(validOut == (i >= 6), "R8 fill", int'(validOut), int'(i >= 6));
    end

    runStream();

    // hold all +1 and check the clamp in steady state
    stageDec = {STAGES{P}};
    repeat (8) @(posedge clk);
    #1;
    chk(dataOut == 10'h3FF, "R6 steady clamp", int'(dataOut), 1023);

    @(negedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1;
    chk(dataOut == '0, "R7 mid reset data", int'(dataOut), 0);
    chk(!validOut, "R7 mid reset valid", int'(validOut), 0);

    @(negedge clk);
    #1 rst = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk(!validOut, "R8 refill early", int'(validOut), 0);
    @(posedge clk);
    #1;
    chk(validOut && dataOut == 10'h3FF, "R8 refill done", int'(dataOut), 1023);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule